// File: doc/BRIEF.md
# Double-Buffered Channel Attenuation Registers

This block stores volume settings for eight audio output channels, four left and four right. A simple bus writes to it with a write enable, a 5-bit address and a 9-bit data word. Every channel has two storage stages. The first is a staging copy that any write may change. The second is the live copy, which drives the block's outputs. Software can stage new levels on several channels one at a time and then switch all of them together. This avoids uneven level changes between channels.

Each data word holds three fields. The low seven bits are the attenuation code. Bit 7 is a zero-cross enable for the channel. Bit 8 is a request to commit. The commit request is not stored as a field. Instead it arms a pending flag. On the next sample strobe, every staging copy moves to its live copy and the flag clears. A further address, the broadcast register, loads the same code into the staging copy of all eight channels in a single access. The serial control port and the analogue gain stage lie outside this block.

Top module: `att_bank`

## Requirements
- R1: After reset, every live and staging attenuation code is 127 (0 dB), every zero-cross enable is 0, and `commit_pending` is 0.
- R2: A write with bit 8 equal to 0 changes only the staging copy of the addressed channel. The outputs `att_code` and `zc_en` do not change.
- R3: A write to address 0 to 8 with bit 8 equal to 1 stores its fields as usual and sets `commit_pending` at the next edge. The live outputs do not change on that write.
- R4: On an edge where `commit_pending` is 1 and `sample_tick` is 1, all eight live codes and zero-cross enables load from their staging copies, and `commit_pending` clears.
- R5: `sample_tick` has no effect on the outputs while `commit_pending` is 0.
- R6: A write to address 8 (the broadcast register) loads its code into the staging copy of all eight channels.
- R7: A broadcast write with bit 8 equal to 1 also loads bit 7 into every staging zero-cross enable. A broadcast write with bit 8 equal to 0 leaves the staging zero-cross enables unchanged.
- R8: The code is 127 minus the attenuation in dB. Any written code below 27 (-100 dB) is stored as 27.
- R9: The channel addresses are 0 to 7, in the order L1, R1, L2, R2, L3, R3, L4, R4. Output slice `att_code[7*k+6:7*k]` and bit `zc_en[k]` belong to address k. A write to an address from 9 to 31 has no effect, even with bit 8 set.
- R10: When a write and a committing sample strobe fall on the same edge, the commit uses the staging values from before that write. If the write has bit 8 set, `commit_pending` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_addr | input | 5 | Register address |
| wr_data | input | 9 | Bit 8 = commit request, bit 7 = zero-cross enable, bits 6:0 = attenuation code |
| sample_tick | input | 1 | One-cycle pulse for each input sample |
| att_code | output | 56 | Live 7-bit codes, channel k at bits 7k+6:7k |
| zc_en | output | 8 | Live zero-cross enable per channel |
| commit_pending | output | 1 | A commit is waiting for the next sample strobe |

## Verification
The hardest case to reach is a write that lands on the same edge as the sample strobe that commits an earlier request. In that case the old staging values must move to the live copy while the new write goes only to the staging copy. The bench drives this collision with directed steps, once with a commit request on the colliding write and once without. The random phase then pulses the strobe often enough that collisions with pending commits happen many times. Each result is compared against a reference model that applies the commit before the write.

// File: rtl/att_bank.sv
module att_bank #(
  parameter int NCH         = 8,
  parameter int AW          = 5,
  parameter int CW          = 7,
  parameter int FLOOR       = 27,
  parameter int MASTER_ADDR = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [CW+1:0]       wr_data,
  input  logic                sample_tick,
  output logic [NCH*CW-1:0]   att_code,
  output logic [NCH-1:0]      zc_en,
  output logic                commit_pending
);
  localparam int CHW = $clog2(NCH);
  localparam logic [AW-1:0] MADDR   = AW'(MASTER_ADDR);
  localparam logic [AW-1:0] NCH_A   = AW'(NCH);
  localparam logic [CW-1:0] FLOOR_C = CW'(FLOOR);
  localparam logic [CW-1:0] ZERO_DB = {CW{1'b1}};

  logic [NCH-1:0][CW-1:0] pre_q, act_q;
  logic [NCH-1:0]         pzc_q, azc_q;
  logic                   pend_q;

  wire [CW-1:0] code     = (wr_data[CW-1:0] < FLOOR_C) ? FLOOR_C : wr_data[CW-1:0];
  wire          zc_bit   = wr_data[CW];
  wire          upd_bit  = wr_data[CW+1];
  wire          is_mst   = wr_en && (wr_addr == MADDR);
  wire          is_ch    = wr_en && (wr_addr < NCH_A);
  wire          upd_req  = (is_mst || is_ch) && upd_bit;
  wire          commit   = pend_q && sample_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q  <= {NCH{ZERO_DB}};
      act_q  <= {NCH{ZERO_DB}};
      pzc_q  <= '0;
      azc_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (commit) begin
        act_q <= pre_q;
        azc_q <= pzc_q;
      end
      if (is_mst) begin
        for (int i = 0; i < NCH; i++) begin
          pre_q[i] <= code;
          if (upd_bit) pzc_q[i] <= zc_bit;
        end
      end else if (is_ch) begin
        pre_q[wr_addr[CHW-1:0]] <= code;
        pzc_q[wr_addr[CHW-1:0]] <= zc_bit;
      end
      if (upd_req)          pend_q <= 1'b1;
      else if (sample_tick) pend_q <= 1'b0;
    end
  end

  assign att_code       = act_q;
  assign zc_en          = azc_q;
  assign commit_pending = pend_q;

  AST_HOLD_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_pending && sample_tick) |=> ($stable(att_code) && $stable(zc_en))); // R2
  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[CW+1] && (wr_addr <= MADDR)) |=> commit_pending); // R3
  AST_COMMIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_pending && sample_tick) |=> (att_code == $past(pre_q) && zc_en == $past(pzc_q))); // R4
  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && !wr_en) |=> !commit_pending); // R4
  AST_IDLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_pending && sample_tick) |=> $stable(att_code)); // R5
  AST_FOREIGN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr > MADDR) |=> $stable(pre_q)); // R9

  for (genvar g = 0; g < NCH; g++) begin : g_floor
    AST_CODE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      act_q[g] >= FLOOR_C && pre_q[g] >= FLOOR_C); // R8
  end
endmodule

// File: tb/att_bank_test.sv
module att_bank_test;
  localparam int CLK_P = 10;
  localparam int NCH = 8;
  localparam int CW = 7;

  logic clk = 0, rst_n = 0, wr_en = 0, sample_tick = 0;
  logic [4:0] wr_addr = 0;
  logic [8:0] wr_data = 0;
  logic [NCH*CW-1:0] att_code;
  logic [NCH-1:0] zc_en;
  logic commit_pending;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [CW-1:0] mp [NCH];
  logic [CW-1:0] ma [NCH];
  logic [NCH-1:0] mpz, maz;
  logic mpend;

  att_bank uut (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .sample_tick,
                .att_code, .zc_en, .commit_pending);

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [CW-1:0] clampf(logic [CW-1:0] c);
    return (c < 7'd27) ? 7'd27 : c;
  endfunction

  function automatic logic [NCH*CW-1:0] exp_codes();
    logic [NCH*CW-1:0] v;
    for (int i = 0; i < NCH; i++) v[i*CW +: CW] = ma[i];
    return v;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NCH; i++) begin mp[i] = 7'h7f; ma[i] = 7'h7f; end
    mpz = '0; maz = '0; mpend = 0;
  endtask

  task automatic model_step(bit we, logic [4:0] a, logic [8:0] d, bit tk);
    bit cm = mpend && tk;
    bit up = we && d[8] && (a <= 5'd8);
    if (cm) begin
      for (int i = 0; i < NCH; i++) ma[i] = mp[i];
      maz = mpz;
    end
    if (we && a == 5'd8) begin
      for (int i = 0; i < NCH; i++) mp[i] = clampf(d[6:0]);
      if (d[8]) mpz = {NCH{d[7]}};
    end else if (we && a < 5'd8) begin
      mp[a[2:0]] = clampf(d[6:0]);
      mpz[a[2:0]] = d[7];
    end
    if (up) mpend = 1;
    else if (tk) mpend = 0;
  endtask

  task automatic check(string tag);
    logic [NCH*CW-1:0] e = exp_codes();
    checks++;
    if (att_code !== e || zc_en !== maz || commit_pending !== mpend) begin
      errors++;
      $display("FAIL %s: got code=%h zc=%b pend=%b, exp code=%h zc=%b pend=%b",
               tag, att_code, zc_en, commit_pending, e, maz, mpend);
    end
  endtask

  task automatic step(bit we, logic [4:0] a, logic [8:0] d, bit tk, string tag);
    wr_en = we; wr_addr = a; wr_data = d; sample_tick = tk;
    model_step(we, a, d, tk);
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; sample_tick = 0;
    check(tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang, exp finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 reset");
    step(1, 5'd2, {1'b0, 1'b1, 7'd100}, 0, "R2 stage only");
    step(0, 5'd0, 9'd0, 1, "R5 tick idle");
    step(1, 5'd7, {1'b1, 1'b1, 7'd90}, 0, "R3 commit armed");
    step(0, 5'd0, 9'd0, 0, "R3 waits for tick");
    step(0, 5'd0, 9'd0, 1, "R4 commit on tick");
    step(1, 5'd8, {1'b0, 1'b1, 7'd60}, 0, "R6 broadcast stage");
    step(1, 5'd1, {1'b1, 1'b0, 7'd3}, 0, "R8 clamp low code");
    step(0, 5'd0, 9'd0, 1, "R6 R8 commit");
    step(1, 5'd8, {1'b1, 1'b1, 7'd70}, 0, "R7 broadcast zc");
    step(0, 5'd0, 9'd0, 1, "R7 commit");
    step(1, 5'd12, {1'b1, 1'b0, 7'd30}, 1, "R9 foreign addr");
    step(1, 5'd31, {1'b1, 1'b1, 7'd40}, 1, "R9 foreign addr top");
    step(1, 5'd6, {1'b1, 1'b0, 7'd50}, 0, "R9 L4 slot");
    step(1, 5'd3, {1'b0, 1'b1, 7'd44}, 1, "R10 collide no update");
    step(1, 5'd4, {1'b1, 1'b0, 7'd33}, 0, "R10 arm");
    step(1, 5'd5, {1'b1, 1'b1, 7'd88}, 1, "R10 collide with update");
    step(0, 5'd0, 9'd0, 1, "R10 second commit");
    for (int n = 0; n < 3000; n++) begin
      bit we = ($urandom % 3) != 0;
      logic [4:0] a = 5'($urandom % 12);
      logic [8:0] d = 9'($urandom);
      bit tk = ($urandom % 4) == 0;
      step(we, a, d, tk, "RND R2 R3 R4 R6 R7 R8 R10");
    end
    rst_n = 0;
    model_reset();
    @(posedge clk); @(negedge clk);
    rst_n = 1;
    check("R1 reset again");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule